// File: doc/BRIEF.md
# Debug Port Pin Release Controller

This block decides, pin by pin, whether five pads shared between a combined JTAG/serial-wire debug port and general-purpose I/O belong to the debug logic or to the GPIO controller. A two-bit configuration word picks one of four assignment modes. The modes are nested, so moving between any two of them either only gives pins up or only takes pins back. The block drives an ownership vector toward the pad multiplexer. It also selects which pad output enable reaches each pin. On the core side, it feeds the debug core either the live pad value or a fixed safe level.

Giving a pin away is done in two steps. First the core input is clamped to its safe level. One edge later, pad ownership moves to GPIO, so the write that started it needs one extra cycle before it is acknowledged. Taking a pin back runs the other way round: ownership comes back first, and the clamp is lifted one cycle later. Writes use a valid/ready handshake. A write offered while a handover is still in flight waits until that handover finishes.

Top module: `pin_release_ctrl`

## Requirements
- R1: After reset is asserted, mode 0 is active. All five pins are debug-owned (`pin_dbg_o` = 5'b11111), `cfg_ready_o` is 1, `trace_sel_o` is 0, and `core_in_o` equals `pad_in_i`.
- R2: The ownership mask in `pin_dbg_o` follows the settled mode. Bit 0 is the select/data pin, bit 1 the clock, bit 2 the data-in, bit 3 the data-out and bit 4 the test reset. Mode 0 gives 5'b11111, mode 1 gives 5'b01111, mode 2 gives 5'b00011 and mode 3 gives 5'b00000.
- R3: A write that releases pins keeps `cfg_ready_o` low in its first cycle and completes on the second clock edge. The released pins show the clamp after the first edge while still debug-owned, and become GPIO-owned after the second edge.
- R4: The safe level forced on a released pin's core input is 1 for select/data, 0 for clock, 1 for data-in, 0 for data-out and 1 for test reset (5'b10101 in pin order).
- R5: A write that only reclaims pins completes on its first edge. Ownership returns at that edge, the clamp is held for one further cycle, and after that the pad value passes through.
- R6: In the cycle after a reclaiming write, `cfg_ready_o` is 0. A write offered then is stalled and changes nothing until that cycle has passed.
- R7: On a debug-owned pin, `pad_oe_o` follows `dbg_oe_i`. Once any clamp is lifted, `core_in_o` follows `pad_in_i`.
- R8: On a GPIO-owned pin, `pad_oe_o` follows `gpio_oe_i`.
- R9: `trace_sel_o` is 1 only when `trace_en_i` is 1, the data-out pin is GPIO-owned and the clock pin is still debug-owned (mode 2). While `trace_sel_o` is 1, `pad_oe_o[3]` is 1.
- R10: A write of the mode already active completes in one cycle and leaves ownership and core inputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_valid_i | input | 1 | Mode write request, held until accepted |
| cfg_mode_i | input | 2 | Requested assignment mode |
| cfg_ready_o | output | 1 | Write completes on this edge when high |
| trace_en_i | input | 1 | Allows trace to drive the data-out pin |
| pad_in_i | input | 5 | Input values from the five pads |
| dbg_oe_i | input | 5 | Debug-side drive enables |
| gpio_oe_i | input | 5 | GPIO-side drive enables |
| core_in_o | output | 5 | Inputs presented to the debug core |
| pad_oe_o | output | 5 | Drive enables toward the pads |
| pin_dbg_o | output | 5 | Per-pin ownership, 1 = debug |
| trace_sel_o | output | 1 | Data-out pin carries trace |

## Verification
A clamp register that drops a bit too early lets a pad level through to `core_in_o` on a pin that has just been handed over or reclaimed. That is visible within one cycle of the owning write, so the bench samples every cycle of each handover. An ownership register stuck at a wrong value shows up as a `pad_oe_o` bit taken from the wrong side, and as a `pin_dbg_o` value outside the four legal masks, on the first sample after the write settles. A handshake state that fails to return to idle holds `cfg_ready_o` low. The next write then takes more cycles than R3, R5 or R10 allow.

// File: rtl/pin_release_pkg.sv
package pin_release_pkg;
  localparam int unsigned NPIN   = 5;
  localparam int unsigned MODE_W = 2;

  localparam int unsigned PIN_SEL  = 0;
  localparam int unsigned PIN_CLK  = 1;
  localparam int unsigned PIN_DIN  = 2;
  localparam int unsigned PIN_DOUT = 3;
  localparam int unsigned PIN_RST  = 4;

  // level each core input takes once its pin is released
  localparam logic [NPIN-1:0] SAFE_LVL = 5'b10101;

  typedef enum logic [MODE_W-1:0] {
    MODE_FULL    = 2'd0,
    MODE_NO_RST  = 2'd1,
    MODE_SW_ONLY = 2'd2,
    MODE_OFF     = 2'd3
  } swj_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CLAMP   = 2'd1,
    ST_UNCLAMP = 2'd2
  } hand_st_e;

  function automatic logic [NPIN-1:0] mode_mask(input logic [MODE_W-1:0] m);
    case (swj_mode_e'(m))
      MODE_FULL:    mode_mask = 5'b11111;
      MODE_NO_RST:  mode_mask = 5'b01111;
      MODE_SW_ONLY: mode_mask = 5'b00011;
      default:      mode_mask = 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/pdr_mode_dec.sv
module pdr_mode_dec
  import pin_release_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NPIN-1:0]   own_i,
  output logic [NPIN-1:0]   mask_o,
  output logic [NPIN-1:0]   rel_o,
  output logic [NPIN-1:0]   acq_o
);
  always_comb begin
    mask_o = mode_mask(mode_i);
    rel_o  = own_i & ~mask_o;
    acq_o  = mask_o & ~own_i;
  end
endmodule

// File: rtl/pdr_handover.sv
module pdr_handover
  import pin_release_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [NPIN-1:0]     rel_i,
  input  logic [NPIN-1:0]     acq_i,
  output logic                ready_o,
  output logic [NPIN-1:0]     own_o,
  output logic [NPIN-1:0]     clamp_o
);
  hand_st_e        st_q, st_d;
  logic [NPIN-1:0] own_q, own_d;
  logic [NPIN-1:0] clamp_q, clamp_d;
  logic [NPIN-1:0] pend_q, pend_d;

  always_comb begin
    st_d    = st_q;
    own_d   = own_q;
    clamp_d = clamp_q;
    pend_d  = pend_q;
    ready_o = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i && |rel_i) begin
          ready_o = 1'b0;
          clamp_d = clamp_q | rel_i;
          pend_d  = rel_i;
          st_d    = ST_CLAMP;
        end else if (req_valid_i && |acq_i) begin
          own_d  = own_q | acq_i;
          pend_d = acq_i;
          st_d   = ST_UNCLAMP;
        end
      end
      ST_CLAMP: begin
        own_d = own_q & ~pend_q;
        st_d  = ST_IDLE;
      end
      ST_UNCLAMP: begin
        ready_o = 1'b0;
        clamp_d = clamp_q & ~pend_q;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      own_q   <= '1;
      clamp_q <= '0;
      pend_q  <= '0;
    end else begin
      st_q    <= st_d;
      own_q   <= own_d;
      clamp_q <= clamp_d;
      pend_q  <= pend_d;
    end
  end

  assign own_o   = own_q;
  assign clamp_o = clamp_q;
endmodule

// File: rtl/pdr_pin_slice.sv
module pdr_pin_slice #(
  parameter logic SAFE_BIT = 1'b0
) (
  input  logic own_i,
  input  logic clamp_i,
  input  logic pad_in_i,
  input  logic dbg_oe_i,
  input  logic gpio_oe_i,
  input  logic trace_i,
  output logic core_in_o,
  output logic pad_oe_o
);
  assign core_in_o = clamp_i ? SAFE_BIT : pad_in_i;
  assign pad_oe_o  = own_i ? dbg_oe_i : (gpio_oe_i | trace_i);
endmodule

// File: rtl/pin_release_ctrl.sv
module pin_release_ctrl
  import pin_release_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  output logic              cfg_ready_o,
  input  logic              trace_en_i,
  input  logic [NPIN-1:0]   pad_in_i,
  input  logic [NPIN-1:0]   dbg_oe_i,
  input  logic [NPIN-1:0]   gpio_oe_i,
  output logic [NPIN-1:0]   core_in_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic [NPIN-1:0]   pin_dbg_o,
  output logic              trace_sel_o
);
  logic [NPIN-1:0] mask_w, rel_w, acq_w;
  logic [NPIN-1:0] own_w, clamp_w, trace_vec_w;

  pdr_mode_dec u_dec (
    .mode_i (cfg_mode_i),
    .own_i  (own_w),
    .mask_o (mask_w),
    .rel_o  (rel_w),
    .acq_o  (acq_w)
  );

  pdr_handover u_hand (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (cfg_valid_i),
    .rel_i       (rel_w),
    .acq_i       (acq_w),
    .ready_o     (cfg_ready_o),
    .own_o       (own_w),
    .clamp_o     (clamp_w)
  );

  // trace takes data-out only while serial-wire keeps its clock
  assign trace_sel_o = trace_en_i & ~own_w[PIN_DOUT] & own_w[PIN_CLK];

  always_comb begin
    trace_vec_w           = '0;
    trace_vec_w[PIN_DOUT] = trace_sel_o;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pdr_pin_slice #(.SAFE_BIT(SAFE_LVL[i])) u_slice (
      .own_i     (own_w[i]),
      .clamp_i   (clamp_w[i]),
      .pad_in_i  (pad_in_i[i]),
      .dbg_oe_i  (dbg_oe_i[i]),
      .gpio_oe_i (gpio_oe_i[i]),
      .trace_i   (trace_vec_w[i]),
      .core_in_o (core_in_o[i]),
      .pad_oe_o  (pad_oe_o[i])
    );
  end

  assign pin_dbg_o = own_w;

  logic unused_w;
  assign unused_w = ^mask_w;
endmodule

// File: rtl/pin_release_chk.sv
module pin_release_chk
  import pin_release_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_valid_i,
  input logic            cfg_ready_o,
  input logic            trace_en_i,
  input logic            trace_sel_o,
  input logic [NPIN-1:0] pad_in_i,
  input logic [NPIN-1:0] core_in_o,
  input logic [NPIN-1:0] pin_dbg_o,
  input logic [NPIN-1:0] clamp_w
);
  assert_legal_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_dbg_o == 5'b11111) || (pin_dbg_o == 5'b01111) ||
    (pin_dbg_o == 5'b00011) || (pin_dbg_o == 5'b00000));

  assert_clamp_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pin_dbg_o) & ~pin_dbg_o & ~$past(clamp_w)) == '0);

  assert_safe_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((core_in_o ^ SAFE_LVL) & ~pin_dbg_o) == '0);

  assert_own_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_dbg_o & ~$past(pin_dbg_o) & ~clamp_w) == '0);

  assert_ready_back_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_ready_o && !cfg_valid_i) |=> cfg_ready_o);

  assert_pad_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((core_in_o ^ pad_in_i) & pin_dbg_o & ~clamp_w) == '0);

  assert_trace_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_sel_o |-> (trace_en_i && !pin_dbg_o[PIN_DOUT] && pin_dbg_o[PIN_CLK]));
endmodule

bind pin_release_ctrl pin_release_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_valid_i (cfg_valid_i),
  .cfg_ready_o (cfg_ready_o),
  .trace_en_i  (trace_en_i),
  .trace_sel_o (trace_sel_o),
  .pad_in_i    (pad_in_i),
  .core_in_o   (core_in_o),
  .pin_dbg_o   (pin_dbg_o),
  .clamp_w     (clamp_w)
);

// File: tb/sim_pin_release_ctrl.sv
`timescale 1ns/1ps
module sim_pin_release_ctrl;
  localparam logic [4:0] SAFE = 5'b10101;
  localparam int NV = 10;
  // {mode, pad_in, dbg_oe, gpio_oe, trace_en, expected ownership}
  localparam logic [22:0] VEC [0:NV-1] = '{
    {2'd0, 5'b10110, 5'b00101, 5'b11010, 1'b0, 5'b11111},
    {2'd0, 5'b01001, 5'b11010, 5'b00101, 1'b1, 5'b11111},
    {2'd1, 5'b00000, 5'b01111, 5'b10000, 1'b0, 5'b01111},
    {2'd1, 5'b11111, 5'b00000, 5'b11111, 1'b1, 5'b01111},
    {2'd2, 5'b01010, 5'b00011, 5'b10100, 1'b0, 5'b00011},
    {2'd2, 5'b10101, 5'b00000, 5'b00000, 1'b1, 5'b00011},
    {2'd3, 5'b01010, 5'b11111, 5'b01001, 1'b1, 5'b00000},
    {2'd3, 5'b11111, 5'b00000, 5'b10110, 1'b0, 5'b00000},
    {2'd2, 5'b00110, 5'b11100, 5'b11111, 1'b1, 5'b00011},
    {2'd0, 5'b11001, 5'b10011, 5'b01100, 1'b1, 5'b11111}
  };

  logic clk_i = 0, rst_ni = 0;
  logic cfg_valid_i = 0, trace_en_i = 0;
  logic [1:0] cfg_mode_i = 0;
  logic [4:0] pad_in_i = 0, dbg_oe_i = 0, gpio_oe_i = 0;
  logic cfg_ready_o, trace_sel_o;
  logic [4:0] core_in_o, pad_oe_o, pin_dbg_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [1:0] cur_mode = 0;

  always #10 clk_i = ~clk_i;

  pin_release_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] mask_of(input logic [1:0] m);
    case (m)
      2'd0: return 5'b11111;
      2'd1: return 5'b01111;
      2'd2: return 5'b00011;
      default: return 5'b00000;
    endcase
  endfunction

  // called at a negedge; returns at the negedge after the completing edge
  task automatic write_mode(input logic [1:0] m, output int cyc);
    logic rdy;
    cfg_valid_i = 1; cfg_mode_i = m; cyc = 0;
    forever begin
      #1 rdy = cfg_ready_o;
      @(posedge clk_i); cyc++;
      if (rdy) break;
      @(negedge clk_i);
    end
    @(negedge clk_i);
    cfg_valid_i = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [4:0] m, cexp, oexp;
    logic texp;
    pad_in_i = 5'b01010;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 own", pin_dbg_o, 5'b11111);
    chk("R1 ready", cfg_ready_o, 1);
    chk("R1 core", core_in_o, 5'b01010);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk("R1 trace", trace_sel_o, 0);

    // vector walk over settled modes
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      if (VEC[v][22:21] != cur_mode) begin
        logic [4:0] om, nm;
        om = mask_of(cur_mode); nm = mask_of(VEC[v][22:21]);
        write_mode(VEC[v][22:21], cyc);
        if (|(om & ~nm)) chk("R3 release cycles", cyc, 2);
        else chk("R5 reclaim cycles", cyc, 1);
        cur_mode = VEC[v][22:21];
        @(negedge clk_i);
      end
      pad_in_i = VEC[v][20:16]; dbg_oe_i = VEC[v][15:11];
      gpio_oe_i = VEC[v][10:6]; trace_en_i = VEC[v][5];
      #1;
      m = VEC[v][4:0];
      texp = trace_en_i && (cur_mode == 2'd2);
      cexp = (m & pad_in_i) | (~m & SAFE);
      oexp = (m & dbg_oe_i) | (~m & gpio_oe_i);
      if (texp) oexp[3] = 1'b1;
      chk("R2 own", pin_dbg_o, m);
      chk("R4 R7 core", core_in_o, cexp);
      chk("R7 R8 oe", pad_oe_o, oexp);
      chk("R9 trace", trace_sel_o, texp);
    end

    // R10: same mode again (mode 0)
    @(negedge clk_i);
    pad_in_i = 5'b00000; trace_en_i = 0;
    write_mode(2'd0, cyc);
    chk("R10 cycles", cyc, 1);
    #1 chk("R10 ready", cfg_ready_o, 1);
    chk("R10 own", pin_dbg_o, 5'b11111);
    chk("R10 core", core_in_o, 5'b00000);

    // R3 step by step: release test reset pin
    cfg_valid_i = 1; cfg_mode_i = 2'd1;
    #1 chk("R3 ready low", cfg_ready_o, 0);
    chk("R3 core before", core_in_o[4], 0);
    @(negedge clk_i); #1;
    chk("R3 clamp first", core_in_o[4], 1);
    chk("R3 still owned", pin_dbg_o[4], 1);
    chk("R3 ready high", cfg_ready_o, 1);
    @(negedge clk_i); cfg_valid_i = 0; #1;
    chk("R3 released", pin_dbg_o, 5'b01111);
    chk("R4 rst level", core_in_o[4], 1);

    // R5/R6: reclaim, then stall a release offered in the unclamp cycle
    @(negedge clk_i);
    cfg_valid_i = 1; cfg_mode_i = 2'd0;
    #1 chk("R5 ready", cfg_ready_o, 1);
    @(negedge clk_i);
    cfg_mode_i = 2'd3; #1;
    chk("R5 own back", pin_dbg_o, 5'b11111);
    chk("R5 clamp held", core_in_o[4], 1);
    chk("R6 ready low", cfg_ready_o, 0);
    @(negedge clk_i); #1;
    chk("R5 clamp lifted", core_in_o[4], 0);
    chk("R6 stalled", pin_dbg_o, 5'b11111);
    chk("R6 release pending", cfg_ready_o, 0);
    @(negedge clk_i); #1;
    chk("R6 ready", cfg_ready_o, 1);
    @(negedge clk_i); cfg_valid_i = 0; #1;
    chk("R2 mode3", pin_dbg_o, 5'b00000);
    chk("R4 all safe", core_in_o, SAFE);

    // R9: trace off in mode 3 even when enabled
    trace_en_i = 1; gpio_oe_i = 0; #1;
    chk("R9 mode3 trace", trace_sel_o, 0);
    chk("R9 mode3 oe", pad_oe_o, 5'b00000);

    // R1: reset from mode 3
    rst_ni = 0; #1;
    chk("R1 async own", pin_dbg_o, 5'b11111);
    chk("R1 async core", core_in_o, pad_in_i);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i); #1;
    chk("R1 after reset ready", cfg_ready_o, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule